// File: doc/BRIEF.md
# Write-Only Two-Wire Control Slave

This block is a target on a two-wire control bus that only takes writes. The block samples the clock and data lines on its own system clock and recognises start and stop conditions. After a start, it checks the first byte against its own device address. The top six address bits are fixed by a parameter, and the lowest bit comes from a select pin. The block acknowledges only when the address matches and the direction bit asks for a write. Two data bytes follow, and the block acknowledges each one.

The two data bytes form a 16-bit control word. The upper seven bits of that word are a register address and the lower nine bits are the register value. When the second byte has been acknowledged, the block presents the address and value on its outputs and pulses a write strobe for one system clock. It never drives the data line high. Its only drive is an open-drain enable: when that enable is high, the pad pulls the line low. Reads, clock stretching and arbitration between several masters are not supported.

Top module: `ctl2wSlave`

## Requirements
- R1: After reset, `sdaOe` and `wrStrobe` are 0, and `regAddr` and `regData` are all zeros.
- R2: A start is a falling edge on the data line while the clock line is high. After a start, the block samples eight bits on the rising edges of the clock line, most significant bit first. The first seven bits are the device address, and the eighth bit is the direction bit (0 = write).
- R3: The device address is 7'b0011010 when `addrSel` is 0 and 7'b0011011 when `addrSel` is 1. Any other address gets no acknowledge and causes no write.
- R4: When the direction bit is 1 the block never acknowledges. Bytes that follow without a new start get no acknowledge and cause no write.
- R5: For a matching write address, the block acknowledges the address byte and each of the two data bytes. It does this by holding `sdaOe` at 1 while the clock line is high during the ninth clock pulse.
- R6: The word is {first data byte, second data byte}. `regAddr` takes word[15:9] and `regData` takes word[8:0]. `wrStrobe` is 1 for exactly one system cycle. That cycle is the third system clock edge after the clock line falls to end the ninth pulse of the second data byte.
- R7: A transfer cut short by a stop or a start before the second data byte is acknowledged gives no `wrStrobe`, and `regAddr` and `regData` keep their values.
- R8: A start that arrives in the middle of a transfer (a repeated start) begins address reception again. A full write that follows it updates the outputs.
- R9: A stop is a rising edge on the data line while the clock line is high, and it returns the block to idle. Bits sent after a stop without a new start are ignored and get no acknowledge.
- R10: `sdaOe` goes to 1 only after the falling edge of the clock line that ends the eighth bit. It goes back to 0 after the falling edge that ends the ninth bit. It is 0 while the eighth bit is high on the clock line.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous reset, active low |
| sclIn | input | 1 | Bus clock line as seen at the pad |
| sdaIn | input | 1 | Bus data line as seen at the pad |
| addrSel | input | 1 | Selects the lowest bit of the device address |
| sdaOe | output | 1 | Open-drain enable; 1 pulls the data line low |
| regAddr | output | 7 | Register address of the last completed write |
| regData | output | 9 | Register value of the last completed write |
| wrStrobe | output | 1 | One-cycle pulse when a new write is presented |

## Verification
Each bus input passes through two synchronizer flops and one edge-detect flop before the control logic sees it. As a result, every reaction registers on the third system clock edge after the pin changes. The bench drives each bus phase for eight system cycles. It samples the acknowledge in the middle of the high phase of the ninth pulse, and it checks that the drive is released eight cycles after the ninth falling edge. A monitor records the cycle number of every strobe. The bench compares that number with the cycle of the last ninth falling edge and requires a gap of exactly three cycles.

// File: rtl/ctl2w_pkg.sv
package ctl2w_pkg;

  // Control states of the transfer sequencer
  typedef enum logic [2:0] {
    S_IDLE = 3'd0,  // waiting for a start
    S_ADDR = 3'd1,  // receiving address + direction
    S_AACK = 3'd2,  // acknowledging address
    S_DHI  = 3'd3,  // receiving upper data byte
    S_HACK = 3'd4,  // acknowledging upper byte
    S_DLO  = 3'd5,  // receiving lower data byte
    S_LACK = 3'd6   // acknowledging lower byte
  } ctlState_t;

  // Strobes from the sequencer to the datapath
  typedef struct packed {
    logic shiftEn;  // take one bit into the shifter
    logic clrCnt;   // restart bit counting
    logic ackOn;    // start pulling the data line low
    logic ackOff;   // release the data line
    logic latchHi;  // keep the upper data byte
    logic commit;   // present the word and pulse the strobe
  } ctlStrobes_t;

endpackage

// File: rtl/ctl2wSync.sv
module ctl2wSync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic sclIn,
  input  logic sdaIn,
  output logic sdaLvl,
  output logic sclRise,
  output logic sclFall,
  output logic startEv,
  output logic stopEv
);

  localparam int LAST = STAGES - 1;

  logic [STAGES-1:0] sclPipe;
  logic [STAGES-1:0] sdaPipe;
  logic sclPrev;
  logic sdaPrev;
  logic sclNow;
  logic sdaNow;

  // Both lines idle high, so the chain resets to ones
  generate
    if (STAGES == 1) begin : gOne
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          sclPipe <= '1;
          sdaPipe <= '1;
        end else begin
          sclPipe <= sclIn;
          sdaPipe <= sdaIn;
        end
      end
    end else begin : gChain
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          sclPipe <= '1;
          sdaPipe <= '1;
        end else begin
          sclPipe <= {sclPipe[STAGES-2:0], sclIn};
          sdaPipe <= {sdaPipe[STAGES-2:0], sdaIn};
        end
      end
    end
  endgenerate

  assign sclNow = sclPipe[LAST];
  assign sdaNow = sdaPipe[LAST];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclPrev <= 1'b1;
      sdaPrev <= 1'b1;
    end else begin
      sclPrev <= sclNow;
      sdaPrev <= sdaNow;
    end
  end

  assign sdaLvl  = sdaNow;
  assign sclRise = sclNow & ~sclPrev;
  assign sclFall = ~sclNow & sclPrev;
  // Data moves while the clock line stays high
  assign startEv = sclNow & sclPrev & sdaPrev & ~sdaNow;
  assign stopEv  = sclNow & sclPrev & ~sdaPrev & sdaNow;

endmodule

// File: rtl/ctl2wData.sv
module ctl2wData
  import ctl2w_pkg::*;
#(
  parameter logic [5:0] DEV_BASE   = 6'b001101,
  parameter int         REG_ADDR_W = 7,
  parameter int         REG_DATA_W = 9
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  ctlStrobes_t           ctl,
  input  logic                  sdaLvl,
  input  logic                  addrSel,
  output logic                  byteFull,
  output logic                  addrMatch,
  output logic                  rwBit,
  output logic                  sdaOe,
  output logic [REG_ADDR_W-1:0] regAddr,
  output logic [REG_DATA_W-1:0] regData,
  output logic                  wrStrobe
);

  localparam int BYTE_W = 8;
  localparam int WORD_W = REG_ADDR_W + REG_DATA_W;
  localparam int HI_W   = WORD_W - BYTE_W;
  localparam int CNT_W  = $clog2(BYTE_W + 1);

  logic [BYTE_W-1:0] shiftReg;
  logic [HI_W-1:0]   hiByte;
  logic [CNT_W-1:0]  bitCnt;
  logic [WORD_W-1:0] word;

  // Bit shifter and counter
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftReg <= '0;
      bitCnt   <= '0;
    end else if (ctl.clrCnt) begin
      bitCnt <= '0;
    end else if (ctl.shiftEn) begin
      shiftReg <= {shiftReg[BYTE_W-2:0], sdaLvl};
      bitCnt   <= bitCnt + 1'b1;
    end
  end

  assign byteFull  = (bitCnt == CNT_W'(BYTE_W));
  assign rwBit     = shiftReg[0];
  assign addrMatch = (shiftReg[BYTE_W-1:1] == {DEV_BASE, addrSel});

  // Upper byte holding register
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            hiByte <= '0;
    else if (ctl.latchHi) hiByte <= shiftReg[HI_W-1:0];
  end

  assign word = {hiByte, shiftReg};

  // Acknowledge drive
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)           sdaOe <= 1'b0;
    else if (ctl.ackOff) sdaOe <= 1'b0;
    else if (ctl.ackOn)  sdaOe <= 1'b1;
  end

  // Output register and strobe
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      regAddr  <= '0;
      regData  <= '0;
      wrStrobe <= 1'b0;
    end else begin
      wrStrobe <= ctl.commit;
      if (ctl.commit) begin
        regAddr <= word[WORD_W-1 -: REG_ADDR_W];
        regData <= word[REG_DATA_W-1:0];
      end
    end
  end

  // R6: strobe is never wider than one cycle
  assert_strobe_single_R6: assert property (@(posedge clk) disable iff (!rstN)
    wrStrobe |=> !wrStrobe);

  // R7: outputs move only together with a strobe
  assert_outputs_hold_R7: assert property (@(posedge clk) disable iff (!rstN)
    !wrStrobe |-> ($stable(regAddr) && $stable(regData)));

  // R2: never more than eight bits gathered
  assert_bitcnt_range_R2: assert property (@(posedge clk) disable iff (!rstN)
    bitCnt <= CNT_W'(BYTE_W));

endmodule

// File: rtl/ctl2wCtrl.sv
module ctl2wCtrl
  import ctl2w_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        sclRise,
  input  logic        sclFall,
  input  logic        startEv,
  input  logic        stopEv,
  input  logic        byteFull,
  input  logic        addrMatch,
  input  logic        rwBit,
  output ctlStrobes_t ctl,
  output ctlState_t   stateOut
);

  ctlState_t state;
  ctlState_t nextState;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= S_IDLE;
    else       state <= nextState;
  end

  always_comb begin
    nextState = state;
    ctl       = '0;
    if (stopEv) begin
      nextState  = S_IDLE;
      ctl.ackOff = 1'b1;
      ctl.clrCnt = 1'b1;
    end else if (startEv) begin
      nextState  = S_ADDR;
      ctl.ackOff = 1'b1;
      ctl.clrCnt = 1'b1;
    end else begin
      unique case (state)
        S_ADDR, S_DHI, S_DLO: begin
          if (sclRise && !byteFull) begin
            ctl.shiftEn = 1'b1;
          end else if (sclFall && byteFull) begin
            if (state == S_ADDR) begin
              if (addrMatch && !rwBit) begin
                nextState = S_AACK;
                ctl.ackOn = 1'b1;
              end else begin
                nextState  = S_IDLE;
                ctl.clrCnt = 1'b1;
              end
            end else if (state == S_DHI) begin
              nextState   = S_HACK;
              ctl.ackOn   = 1'b1;
              ctl.latchHi = 1'b1;
            end else begin
              nextState = S_LACK;
              ctl.ackOn = 1'b1;
            end
          end
        end
        S_AACK, S_HACK: begin
          if (sclFall) begin
            ctl.ackOff = 1'b1;
            ctl.clrCnt = 1'b1;
            nextState  = (state == S_AACK) ? S_DHI : S_DLO;
          end
        end
        S_LACK: begin
          if (sclFall) begin
            ctl.ackOff = 1'b1;
            ctl.clrCnt = 1'b1;
            ctl.commit = 1'b1;
            nextState  = S_IDLE;
          end
        end
        default: nextState = S_IDLE;
      endcase
    end
  end

  assign stateOut = state;

  // R4: the address acknowledge is only ever given to a write
  assert_ack_write_only_R4: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_AACK) |-> (!rwBit && addrMatch));

  // R9: a stop always leads to idle
  assert_stop_idle_R9: assert property (@(posedge clk) disable iff (!rstN)
    stopEv |=> (state == S_IDLE));

  // R8: a start always reopens address reception
  assert_start_restart_R8: assert property (@(posedge clk) disable iff (!rstN)
    (startEv && !stopEv) |=> (state == S_ADDR));

endmodule

// File: rtl/ctl2wSlave.sv
module ctl2wSlave
  import ctl2w_pkg::*;
#(
  parameter int         SYNC_STAGES = 2,
  parameter logic [5:0] DEV_BASE    = 6'b001101,
  parameter int         REG_ADDR_W  = 7,
  parameter int         REG_DATA_W  = 9
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  sclIn,
  input  logic                  sdaIn,
  input  logic                  addrSel,
  output logic                  sdaOe,
  output logic [REG_ADDR_W-1:0] regAddr,
  output logic [REG_DATA_W-1:0] regData,
  output logic                  wrStrobe
);

  logic        sdaLvl;
  logic        sclRise;
  logic        sclFall;
  logic        startEv;
  logic        stopEv;
  logic        byteFull;
  logic        addrMatch;
  logic        rwBit;
  ctlStrobes_t ctl;
  ctlState_t   state;

  ctl2wSync #(.STAGES(SYNC_STAGES)) sync_i (
    .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaIn(sdaIn),
    .sdaLvl(sdaLvl), .sclRise(sclRise), .sclFall(sclFall),
    .startEv(startEv), .stopEv(stopEv)
  );

  ctl2wCtrl ctrl_i (
    .clk(clk), .rstN(rstN), .sclRise(sclRise), .sclFall(sclFall),
    .startEv(startEv), .stopEv(stopEv), .byteFull(byteFull),
    .addrMatch(addrMatch), .rwBit(rwBit), .ctl(ctl), .stateOut(state)
  );

  ctl2wData #(
    .DEV_BASE(DEV_BASE), .REG_ADDR_W(REG_ADDR_W), .REG_DATA_W(REG_DATA_W)
  ) data_i (
    .clk(clk), .rstN(rstN), .ctl(ctl), .sdaLvl(sdaLvl), .addrSel(addrSel),
    .byteFull(byteFull), .addrMatch(addrMatch), .rwBit(rwBit),
    .sdaOe(sdaOe), .regAddr(regAddr), .regData(regData), .wrStrobe(wrStrobe)
  );

  // R10: the data line is only pulled during an acknowledge slot
  assert_oe_in_ack_R10: assert property (@(posedge clk) disable iff (!rstN)
    sdaOe |-> (state == S_AACK || state == S_HACK || state == S_LACK));

  // R6: a write follows only the lower-byte acknowledge
  assert_strobe_after_ack_R6: assert property (@(posedge clk) disable iff (!rstN)
    wrStrobe |-> ($past(state) == S_LACK));

endmodule

// File: tb/ctl2wSlave_tb_top.sv
`timescale 1ns/1ps
module ctl2wSlave_tb_top;

  localparam int Q = 8;  // system cycles per bus quarter phase

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       sclM = 1'b1;
  logic       sdaM = 1'b1;
  logic       addrSel = 1'b0;
  logic       sdaOe;
  logic [6:0] regAddr;
  logic [8:0] regData;
  logic       wrStrobe;
  logic       busSda;

  int checks = 0;
  int failures = 0;
  int cyc = 0;
  int stbCnt = 0;
  int stbCyc = 0;
  int wideCnt = 0;
  int fallCyc = 0;
  logic stbPrev = 1'b0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  assign busSda = sdaM & ~sdaOe;

  ctl2wSlave dut_i (
    .clk(clk), .rstN(rstN), .sclIn(sclM), .sdaIn(busSda), .addrSel(addrSel),
    .sdaOe(sdaOe), .regAddr(regAddr), .regData(regData), .wrStrobe(wrStrobe)
  );

  always @(posedge clk) cyc <= cyc + 1;

  // Strobe monitor, sampled away from the active edge
  always @(negedge clk) begin
    if (wrStrobe) begin
      stbCnt = stbCnt + 1;
      stbCyc = cyc;
      if (stbPrev) wideCnt = wideCnt + 1;
    end
    stbPrev = wrStrobe;
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic waitCyc(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic busStart();
    sdaM = 1'b1; waitCyc(Q);
    sclM = 1'b1; waitCyc(Q);
    sdaM = 1'b0; waitCyc(Q);
    sclM = 1'b0; waitCyc(Q);
  endtask

  task automatic busStop();
    sdaM = 1'b0; waitCyc(Q);
    sclM = 1'b1; waitCyc(Q);
    sdaM = 1'b1; waitCyc(Q);
  endtask

  // Sends one byte MSB first; returns the acknowledge level seen
  task automatic sendByte(input logic [7:0] b, output logic acked);
    for (int i = 7; i >= 0; i--) begin
      sdaM = b[i]; waitCyc(Q);
      sclM = 1'b1; waitCyc(Q);
      if (i == 0) chk("R10 oe low in eighth bit", int'(sdaOe), 0);
      waitCyc(Q);
      sclM = 1'b0; waitCyc(Q);
    end
    sdaM = 1'b1; waitCyc(Q);
    sclM = 1'b1; waitCyc(Q);
    acked = (busSda == 1'b0);
    waitCyc(Q);
    sclM = 1'b0;
    fallCyc = cyc;
    waitCyc(Q);
    chk("R10 oe released after ninth", int'(sdaOe), 0);
  endtask

  // Full three-byte write; reports acks
  task automatic writeWord(input logic [6:0] dev, input logic rw, input logic [15:0] w,
                           output logic a0, output logic a1, output logic a2);
    busStart();
    sendByte({dev, rw}, a0);
    sendByte(w[15:8], a1);
    sendByte(w[7:0], a2);
    busStop();
  endtask

  task automatic testReset();
    chk("R1 sdaOe reset", int'(sdaOe), 0);
    chk("R1 wrStrobe reset", int'(wrStrobe), 0);
    chk("R1 regAddr reset", int'(regAddr), 0);
    chk("R1 regData reset", int'(regData), 0);
  endtask

  task automatic testWriteSel0();
    logic a0, a1, a2;
    int s0;
    addrSel = 1'b0;
    s0 = stbCnt;
    writeWord(7'h1A, 1'b0, 16'hA5C3, a0, a1, a2);
    chk("R5 addr ack sel0", int'(a0), 1);
    chk("R5 hi ack", int'(a1), 1);
    chk("R5 lo ack", int'(a2), 1);
    chk("R6 one strobe", stbCnt - s0, 1);
    chk("R6 strobe delay", stbCyc - fallCyc, 3);
    chk("R6 regAddr", int'(regAddr), 'h52);
    chk("R2 R6 regData msb first", int'(regData), 'h1C3);
  endtask

  task automatic testWriteSel1();
    logic a0, a1, a2;
    int s0;
    addrSel = 1'b1;
    s0 = stbCnt;
    writeWord(7'h1B, 1'b0, 16'h3E01, a0, a1, a2);
    chk("R3 ack sel1", int'(a0), 1);
    chk("R6 one strobe sel1", stbCnt - s0, 1);
    chk("R6 regAddr sel1", int'(regAddr), 'h1F);
    chk("R6 regData sel1", int'(regData), 'h001);
    s0 = stbCnt;
    writeWord(7'h1A, 1'b0, 16'hFFFF, a0, a1, a2);
    chk("R3 wrong sel no ack", int'(a0), 0);
    chk("R3 wrong sel no data ack", int'(a1 | a2), 0);
    chk("R3 wrong sel no strobe", stbCnt - s0, 0);
    chk("R3 regAddr kept", int'(regAddr), 'h1F);
    writeWord(7'h5A, 1'b0, 16'h0000, a0, a1, a2);
    chk("R3 foreign addr no ack", int'(a0), 0);
    chk("R3 foreign addr no strobe", stbCnt - s0, 0);
    addrSel = 1'b0;
  endtask

  task automatic testRead();
    logic a0, a1, a2;
    int s0;
    s0 = stbCnt;
    writeWord(7'h1A, 1'b1, 16'h8888, a0, a1, a2);
    chk("R4 read no ack", int'(a0), 0);
    chk("R4 read bytes no ack", int'(a1 | a2), 0);
    chk("R4 read no strobe", stbCnt - s0, 0);
    chk("R4 regData kept", int'(regData), 'h001);
  endtask

  task automatic testPartial();
    logic a0, a1;
    int s0;
    s0 = stbCnt;
    busStart();
    sendByte({7'h1A, 1'b0}, a0);
    sendByte(8'h77, a1);
    busStop();
    chk("R7 partial acks", int'(a0 & a1), 1);
    chk("R7 partial no strobe", stbCnt - s0, 0);
    chk("R7 regAddr kept", int'(regAddr), 'h1F);
    chk("R7 regData kept", int'(regData), 'h001);
  endtask

  task automatic testRepStart();
    logic a0, a1, a2;
    int s0;
    s0 = stbCnt;
    busStart();
    sendByte({7'h1A, 1'b0}, a0);
    sendByte(8'hFF, a1);
    busStart();
    sendByte({7'h1A, 1'b0}, a0);
    sendByte(8'h12, a1);
    sendByte(8'h34, a2);
    busStop();
    chk("R8 acks after repeated start", int'(a0 & a1 & a2), 1);
    chk("R8 single strobe", stbCnt - s0, 1);
    chk("R8 regAddr", int'(regAddr), 'h09);
    chk("R8 regData", int'(regData), 'h034);
  endtask

  task automatic testStopIgnore();
    logic a0, a1;
    int s0;
    s0 = stbCnt;
    busStart();
    sendByte({7'h1A, 1'b0}, a0);
    busStop();
    sclM = 1'b0; waitCyc(Q);
    sendByte({7'h1A, 1'b0}, a1);
    sendByte(8'h55, a1);
    chk("R9 addr acked before stop", int'(a0), 1);
    chk("R9 no ack after stop", int'(a1), 0);
    sclM = 1'b1; waitCyc(Q);
    chk("R9 no strobe after stop", stbCnt - s0, 0);
    chk("R6 strobe width", wideCnt, 0);
  endtask

  task automatic finishRun();
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    waitCyc(4);
    testReset();
    rstN = 1'b1;
    waitCyc(4);
    testWriteSel0();
    testWriteSel1();
    testRead();
    testPartial();
    testRepStart();
    testStopIgnore();
    done = 1'b1;
    finishRun();
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      finishRun();
    end
  end

endmodule